// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Zero-Current Cutoff

This block is the synchronous control core of a half-bridge power stage. It takes a three-level switching command, already decoded to two bits, together with an enable, a fault/inhibit input and an active-low mode pin for light-load operation. From these it produces registered turn-on requests for the high-side and low-side gates. Comparator and gate-sense circuits outside the block supply three digitized feedback bits: one flag per gate that says the gate voltage is below its turn-on threshold, and one flag that reports the switch-node zero crossing.

A gate is turned on only after the opposite gate has been switched off and has been seen below its threshold for a set number of clock cycles. This gives break-before-make operation that follows the real gate voltage and not a fixed delay. The low-side phase can be cut short by the zero-crossing flag when the mode pin selects diode emulation. The flag is ignored for a blanking interval after each low-side rise. Once a cutoff happens, the low-side gate stays off until the next high or mid command, a disable, or a fault. The non-overlap and blanking intervals are parameters counted in clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: When `en` is 0 at a clock edge, both `hs_gate` and `ls_gate` are 0 after that edge, whatever the command and mode pin are.
- R2: With the command at 2'b10 (high), only `hs_gate` is driven on. `ls_gate` is 0 from the first edge that samples the command.
- R3: The command codes 2'b01 and 2'b11 both mean mid level. Either one turns both gates off after the next edge and keeps them off.
- R4: With the command at 2'b00 (low) and `zcd_en_n` at 1, `ls_gate` stays on for the whole low phase, and `zc_det` has no effect on it.
- R5: With the command low and `zcd_en_n` at 0, a `zc_det` sampled at 1 outside the blanking window turns `ls_gate` off at that same edge. It stays off for the rest of the low phase, even after `zc_det` returns to 0.
- R6: `zc_det` is ignored at the first BLANK_CYC edges after the edge that raised `ls_gate`. It is honoured from the edge after those.
- R7: A gate rises only at the edge that ends a run of HS_NOL (high side) or LS_NOL (low side) edges. During that run the gate must be requested, the opposite gate must be off, and the opposite threshold flag (`ls_below` or `hs_below`) must be 1. If any of these fails, the count starts again from zero.
- R8: If the command changes before the non-overlap count completes, the pending turn-on is dropped and the new command is sequenced from the start.
- R9: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R10: The zero-current cutoff is released by a high or mid command, by `en` at 0, or by `fault` at 1. After that, a new low command turns `ls_gate` on again.
- R11: `fault` at 1 at an edge turns both gates off after that edge. After release, a gate turns on only through the normal non-overlap sequence for the command present at that time.
- R12: While `rst` is 1, both gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stage enable |
| pwm_cmd | input | 2 | Command: 2'b10 high, 2'b00 low, 2'b01 or 2'b11 mid |
| zcd_en_n | input | 1 | Active-low mode pin that enables the zero-current cutoff |
| zc_det | input | 1 | Switch-node zero-crossing flag from the comparator |
| hs_below | input | 1 | High-side gate is below its threshold |
| ls_below | input | 1 | Low-side gate is below its threshold |
| fault | input | 1 | Fault or inhibit; forces both gates off |
| hs_gate | output | 1 | High-side gate turn-on request (registered) |
| ls_gate | output | 1 | Low-side gate turn-on request (registered) |

## Verification
The hardest case to reach from the ports is a zero-crossing pulse that lands exactly on the blanking boundary, because the low-side rise itself waits on the non-overlap count. The bench reaches it by timing everything from a known settled state. It starts from mid level with the high-side flag already below threshold, so the low-side rise edge follows from LS_NOL alone. It then sweeps a one-cycle `zc_det` pulse across every offset from just after the rise to past the window. It also holds each threshold flag low for a swept number of cycles, to check that the non-overlap count starts only once the flag rises.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_MID  = 2'b01,
    CMD_HIGH = 2'b10,
    CMD_RSV  = 2'b11
  } pwm_cmd_t;

  localparam int LEG_HS = 0;
  localparam int LEG_LS = 1;
  localparam int NUM_LEGS = 2;

  // Reserved code is treated as mid level (both gates off).
  function automatic logic cmd_is_high(input pwm_cmd_t c);
    return c == CMD_HIGH;
  endfunction

  function automatic logic cmd_is_low(input pwm_cmd_t c);
    return c == CMD_LOW;
  endfunction

endpackage

// File: rtl/hb_leg.sv
// One gate leg: non-overlap counter plus the registered gate request.
module hb_leg #(
  parameter int NOL_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic opp_gate,
  input  logic opp_below,
  output logic gate
);
  localparam int CW = $clog2(NOL_CYC + 1);
  localparam logic [CW-1:0] NOL_END = CW'(NOL_CYC);

  logic [CW-1:0] cnt;
  logic          safe;

  // Turning on is allowed only while the other side is off and measured low.
  assign safe = want && !opp_gate && opp_below;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      gate <= 1'b0;
    end else begin
      if (!safe)
        cnt <= '0;
      else if (cnt != NOL_END)
        cnt <= cnt + 1'b1;
      gate <= want && (gate || (safe && cnt == NOL_END));
    end
  end

  // R7
  rise_after_safe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> ($past(want) && !$past(opp_gate) && $past(opp_below)));

  // R7
  gate_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    !want |=> !gate);

endmodule

// File: rtl/hb_zcd_monitor.sv
// Blanking counter and zero-current cutoff hold for the low-side gate.
module hb_zcd_monitor #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ls_gate,
  input  logic low_phase,
  input  logic zcd_on,
  input  logic zc_det,
  output logic trip,
  output logic hold
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic [BW-1:0] bcnt;
  logic          armed;

  assign armed = ls_gate && (bcnt == BLANK_END);
  assign trip  = low_phase && zcd_on && zc_det && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= '0;
      hold <= 1'b0;
    end else begin
      if (!ls_gate)
        bcnt <= '0;
      else if (bcnt != BLANK_END)
        bcnt <= bcnt + 1'b1;
      // Leaving the low phase (high, mid, disable, fault) releases the hold.
      if (!low_phase)
        hold <= 1'b0;
      else if (trip)
        hold <= 1'b1;
    end
  end

  // R6
  blank_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> !trip);

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    !low_phase |=> !hold);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_pkg::*;
#(
  parameter int HS_NOL    = 3,
  parameter int LS_NOL    = 2,
  parameter int BLANK_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] pwm_cmd,
  input  logic       zcd_en_n,
  input  logic       zc_det,
  input  logic       hs_below,
  input  logic       ls_below,
  input  logic       fault,
  output logic       hs_gate,
  output logic       ls_gate
);
  pwm_cmd_t cmd;
  logic     active;
  logic     high_phase;
  logic     low_phase;
  logic     zcd_trip;
  logic     zcd_hold;

  logic [NUM_LEGS-1:0] want;
  logic [NUM_LEGS-1:0] below;
  logic [NUM_LEGS-1:0] gate;

  assign cmd        = pwm_cmd_t'(pwm_cmd);
  assign active     = en && !fault;
  assign high_phase = active && cmd_is_high(cmd);
  assign low_phase  = active && cmd_is_low(cmd);

  hb_zcd_monitor #(.BLANK_CYC(BLANK_CYC)) u_zcd (
    .clk      (clk),
    .rst      (rst),
    .ls_gate  (gate[LEG_LS]),
    .low_phase(low_phase),
    .zcd_on   (!zcd_en_n),
    .zc_det   (zc_det),
    .trip     (zcd_trip),
    .hold     (zcd_hold)
  );

  assign want[LEG_HS]  = high_phase;
  assign want[LEG_LS]  = low_phase && !zcd_hold && !zcd_trip;
  assign below[LEG_HS] = hs_below;
  assign below[LEG_LS] = ls_below;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam int NOL = (g == LEG_HS) ? HS_NOL : LS_NOL;
    hb_leg #(.NOL_CYC(NOL)) u_leg (
      .clk      (clk),
      .rst      (rst),
      .want     (want[g]),
      .opp_gate (gate[NUM_LEGS-1-g]),
      .opp_below(below[NUM_LEGS-1-g]),
      .gate     (gate[g])
    );
  end

  assign hs_gate = gate[LEG_HS];
  assign ls_gate = gate[LEG_LS];

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  // R1
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_gate && !ls_gate));

  // R11
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!hs_gate && !ls_gate));

  // R3
  mid_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_cmd == 2'b01 || pwm_cmd == 2'b11) |=> (!hs_gate && !ls_gate));

  // R5
  cutoff_holds_chk: assert property (@(posedge clk) disable iff (rst)
    zcd_hold |-> !ls_gate);

  // R4
  no_cutoff_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_gate && zcd_en_n && en && !fault && pwm_cmd == 2'b00) |=> ls_gate);

endmodule

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  localparam int HN = 3;
  localparam int LN = 2;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst, en, zcd_en_n, zc_det, hs_below, ls_below, fault;
  logic [1:0] pwm_cmd;
  logic hs_gate, ls_gate;

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_seq #(.HS_NOL(HN), .LS_NOL(LN), .BLANK_CYC(BL)) u_dut (
    .clk(clk), .rst(rst), .en(en), .pwm_cmd(pwm_cmd), .zcd_en_n(zcd_en_n),
    .zc_det(zc_det), .hs_below(hs_below), .ls_below(ls_below), .fault(fault),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic hs_exp, input logic ls_exp);
    vectors++;
    if (hs_gate !== hs_exp || ls_gate !== ls_exp) begin
      errs++;
      $display("FAIL %s: hs/ls actual %b%b expected %b%b at %0t",
               tag, hs_gate, ls_gate, hs_exp, ls_exp, $time);
    end
  endtask

  task automatic settle(input logic [1:0] c);
    pwm_cmd = c;
    repeat (12) tick();
  endtask

  // Trip the cutoff from mid level, then release it by one of three means.
  task automatic trip_and_release(input int kind);
    settle(2'b01);
    hs_below = 1'b1; zcd_en_n = 1'b0; zc_det = 1'b1; pwm_cmd = 2'b00;
    for (int t = 1; t <= LN + 1 + BL + 2; t++) begin
      tick();
      chk("R5", 1'b0, (t >= LN + 1) && (t < LN + 1 + BL + 1));
    end
    zc_det = 1'b0;
    tick(); chk("R5", 1'b0, 1'b0);
    case (kind)
      0: pwm_cmd = 2'b10;
      1: en = 1'b0;
      default: fault = 1'b1;
    endcase
    ls_below = 1'b0;
    tick(); chk("R10", 1'b0, 1'b0);
    pwm_cmd = 2'b00; en = 1'b1; fault = 1'b0;
    for (int u = 1; u <= LN + 3; u++) begin
      tick();
      chk("R10", 1'b0, u >= LN + 1);
    end
    zcd_en_n = 1'b1;
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; pwm_cmd = 2'b01; zcd_en_n = 1'b1; zc_det = 1'b0;
    hs_below = 1'b1; ls_below = 1'b1; fault = 1'b0;
    repeat (3) tick();
    chk("R12", 1'b0, 1'b0);
    rst = 1'b0; en = 1'b1;

    // R3: both mid encodings
    for (int t = 0; t < 4; t++) begin tick(); chk("R3", 1'b0, 1'b0); end
    pwm_cmd = 2'b11;
    for (int t = 0; t < 4; t++) begin tick(); chk("R3", 1'b0, 1'b0); end

    // First low phase from mid: LS rise after LN sampled safe edges
    pwm_cmd = 2'b00;
    for (int t = 1; t <= LN + 3; t++) begin tick(); chk("R7", 1'b0, t >= LN + 1); end

    // R7 / R2 sweep: threshold flag held low for j ticks in both directions
    for (int j = 1; j <= 6; j++) begin
      ls_below = 1'b0; pwm_cmd = 2'b10;
      for (int t = 1; t <= j + HN + 3; t++) begin
        tick();
        chk((t >= j + 1 + HN) ? "R2" : "R7", t >= j + 1 + HN, 1'b0);
        if (t == j) ls_below = 1'b1;
      end
      hs_below = 1'b0; pwm_cmd = 2'b00;
      for (int t = 1; t <= j + LN + 3; t++) begin
        tick();
        chk("R7", 1'b0, t >= j + 1 + LN);
        if (t == j) hs_below = 1'b1;
      end
    end

    // R4: cutoff disabled, zc_det ignored for the whole low phase
    zcd_en_n = 1'b1; zc_det = 1'b1;
    for (int t = 0; t < 12; t++) begin tick(); chk("R4", 1'b0, 1'b1); end
    zc_det = 1'b0;

    // R8: high request cancelled by mid before the count completes
    ls_below = 1'b1; pwm_cmd = 2'b10;
    tick(); chk("R8", 1'b0, 1'b0);
    tick(); chk("R8", 1'b0, 1'b0);
    pwm_cmd = 2'b01;
    for (int t = 0; t < 6; t++) begin tick(); chk("R8", 1'b0, 1'b0); end
    // R8: low request cancelled by high after one safe edge
    hs_below = 1'b1; pwm_cmd = 2'b00;
    tick(); chk("R8", 1'b0, 1'b0);
    pwm_cmd = 2'b10;
    for (int u = 1; u <= HN + 3; u++) begin tick(); chk("R8", u >= HN + 1, 1'b0); end

    // R6 / R5 sweep: one-cycle zero-crossing pulse at offset s after LS rise
    for (int s = 1; s <= BL + 3; s++) begin
      settle(2'b01);
      hs_below = 1'b1; zcd_en_n = 1'b0; pwm_cmd = 2'b00;
      for (int t = 1; t <= LN + 1 + BL + 7; t++) begin
        tick();
        chk((s <= BL) ? "R6" : "R5", 1'b0,
            (t >= LN + 1) && ((s <= BL) || (t < LN + 1 + s)));
        zc_det = (t == LN + 1 + s - 1);
      end
      zc_det = 1'b0; zcd_en_n = 1'b1;
    end

    // R10: each release path
    for (int k = 0; k < 3; k++) trip_and_release(k);

    // R1: disable while high
    ls_below = 1'b1; settle(2'b10);
    chk("R2", 1'b1, 1'b0);
    en = 1'b0;
    tick(); chk("R1", 1'b0, 1'b0);
    pwm_cmd = 2'b00;
    for (int t = 0; t < 4; t++) begin tick(); chk("R1", 1'b0, 1'b0); end
    pwm_cmd = 2'b10; en = 1'b1;
    for (int u = 1; u <= HN + 2; u++) begin tick(); chk("R1", u >= HN + 1, 1'b0); end

    // R11: fault while high, release into a low command
    fault = 1'b1;
    tick(); chk("R11", 1'b0, 1'b0);
    pwm_cmd = 2'b00; hs_below = 1'b1;
    for (int t = 0; t < 4; t++) begin tick(); chk("R11", 1'b0, 1'b0); end
    fault = 1'b0;
    for (int u = 1; u <= LN + 2; u++) begin tick(); chk("R11", 1'b0, u >= LN + 1); end

    // R9: the two outputs never both high during a fast command toggle
    for (int t = 0; t < 40; t++) begin
      pwm_cmd = (t % 3 == 0) ? 2'b10 : ((t % 3 == 1) ? 2'b00 : 2'b01);
      tick();
      vectors++;
      if (hs_gate && ls_gate) begin
        errs++;
        $display("FAIL R9: hs/ls actual 11 expected not 11 at %0t", $time);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule